// File: doc/BRIEF.md
# Serial Command Slave for a 16-Channel Output Switch

This block is the serial-link front end of a sixteen-channel output switch controller. A host drives chip select, serial clock and serial data in. While chip select is low the block clocks a command word in and, at the same time, clocks a fault status word out. The block applies a command only when chip select returns high. It then copies the channel bits of a valid command into a sixteen-bit output latch, which drives the channel enables of the power stage.

All four serial pins are asynchronous to the block clock. Each pin is passed through a synchronizer, and its edges are detected at the block clock. The status word is captured when chip select falls. It holds an any-fault flag, an overvoltage flag, six zero bits and one fault flag per channel. Because the word is captured at that moment, a fault that changes during the frame does not change the word being returned.

Top module: `spi_out_driver`

## Requirements
- R1: While the asynchronous active-low reset `rstN` is low, `chanOut` is all zeros (all channels off) and `sdoEn` is 0.
- R2: `sdoEn` goes to 1 after chip select falls and returns to 0 after chip select rises. While `sdoEn` is 0, `sdo` is held at 0.
- R3: On the fall of chip select the block captures a 24-bit status word and sends it most significant bit first. Bit 23 is the OR of every channel fault and the overvoltage flag. Bit 22 is the overvoltage flag. Bits 21 to 16 are 0. Bits 15 to 0 are the fault flags of channels 15 down to 0, with 1 meaning faulted. Bit 23 is on `sdo` before the first rising serial clock edge.
- R4: Each rising serial clock edge inside a frame moves `sdo` to the next lower status bit. After bit 0 has been sent, `sdo` shows 0.
- R5: `sdi` is sampled on falling serial clock edges, most significant bit first. In a 24-bit frame, bits 23 to 16 are the opcode and bits 15 to 0 are the channel states, with 1 meaning on. A frame with opcode 8'h00 loads bits 15 to 0 into `chanOut` when chip select rises.
- R6: `chanOut` does not change while a frame is still open.
- R7: A frame with more or fewer than 24 falling clock edges leaves `chanOut` unchanged.
- R8: A 24-bit frame whose opcode is not 8'h00 leaves `chanOut` unchanged.
- R9: While chip select is high, toggling the serial clock and `sdi` has no effect on `chanOut`, `sdo` or `sdoEn`, and has no effect on the next frame.
- R10: If chip select falls while the serial clock is high, the falling clock edge that follows is not counted as a data bit.
- R11: The status word sent during a frame does not change when `faultIn` or `ovIn` change after chip select has fallen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command data from the host |
| faultIn | input | 16 | Fault flag of each channel, 1 means faulted |
| ovIn | input | 1 | Overvoltage flag from the power stage |
| chanOut | output | 16 | Latched channel enables |
| sdo | output | 1 | Serial status data to the host |
| sdoEn | output | 1 | Enable for the external tri-state driver of `sdo` |

## Verification
A bit counter that is off by one turns every frame into a rejected frame. The host sees this as a `chanOut` that never follows its commands, and the error shows at the first chip select rise. A status shifter that is out of step, or captured at the wrong time, shows on `sdo` at the very next rising serial clock edge. A wrong bit position also shows there, as the wrong flag in the wrong slot. A frame-open flag that gets stuck shows as `sdoEn` staying high past chip select release, or as serial activity outside a frame leaking into the next command.

// File: rtl/spi_out_driver_pkg.sv
package spi_out_driver_pkg;

  // Single-cycle strobes from the control path to the datapath
  typedef struct packed {
    logic loadTx;    // capture status word (chip select fell)
    logic shiftTx;   // advance status shifter (rising serial clock)
    logic shiftRx;   // take one command bit (falling serial clock)
    logic commit;    // frame closed with exactly a full word
    logic frameEnd;  // chip select rose
  } strobe_t;

endpackage

// File: rtl/spi_out_driver_ctrl.sv
module spi_out_driver_ctrl
  import spi_out_driver_pkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdi,
  output strobe_t          strb,
  output logic             sdiBit,
  output logic [CNT_W-1:0] bitCount
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, sdiPipe;
  logic csD, sclkD;
  logic csS, sclkS;
  logic armed;
  logic csFall, csRise, sclkRise, sclkFall, inFrame;

  // Synchronizer chains: chip select idles high, clock idles low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      csD      <= 1'b1;
      sclkD    <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      csD      <= csPipe[SYNC_STAGES-1];
      sclkD    <= sclkPipe[SYNC_STAGES-1];
    end
  end

  assign csS    = csPipe[SYNC_STAGES-1];
  assign sclkS  = sclkPipe[SYNC_STAGES-1];
  assign sdiBit = sdiPipe[SYNC_STAGES-1];

  assign csFall  = csD & ~csS;
  assign csRise  = ~csD & csS;
  assign inFrame = ~csD & ~csS & armed;
  assign sclkRise = inFrame & ~sclkD & sclkS;
  assign sclkFall = inFrame & sclkD & ~sclkS;

  // Clock edges count only after the clock has been seen low inside the frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armed <= 1'b0;
    else if (csFall)  armed <= ~sclkS;
    else if (csS)     armed <= 1'b0;
    else if (!sclkS)  armed <= 1'b1;
  end

  // Bit counter saturates one past a full word so long frames never alias
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               bitCount <= '0;
    else if (csFall)                         bitCount <= '0;
    else if (sclkFall && bitCount != OVER_CNT) bitCount <= bitCount + 1'b1;
  end

  always_comb begin
    strb          = '0;
    strb.loadTx   = csFall;
    strb.shiftTx  = sclkRise;
    strb.shiftRx  = sclkFall;
    strb.frameEnd = csRise;
    strb.commit   = csRise && (bitCount == FULL_CNT);
  end

endmodule

// File: rtl/spi_out_driver_datapath.sv
module spi_out_driver_datapath
  import spi_out_driver_pkg::*;
#(
  parameter int CHANNELS   = 16,
  parameter int FRAME_BITS = 24,
  parameter int OP_W       = FRAME_BITS - CHANNELS,
  parameter logic [OP_W-1:0] SET_OPCODE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                sdiBit,
  input  logic [CHANNELS-1:0] faultIn,
  input  logic                ovIn,
  output logic [CHANNELS-1:0] chanOut,
  output logic                sdo,
  output logic                sdoEn
);

  localparam int PAD_W = FRAME_BITS - CHANNELS - 2;

  logic [FRAME_BITS-1:0] txShift, rxShift, statusWord;
  logic anyFault;

  assign anyFault   = (|faultIn) | ovIn;
  assign statusWord = {anyFault, ovIn, {PAD_W{1'b0}}, faultIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= '0;
    else if (strb.loadTx)  txShift <= statusWord;
    else if (strb.shiftTx) txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxShift <= '0;
    else if (strb.shiftRx) rxShift <= {rxShift[FRAME_BITS-2:0], sdiBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sdoEn <= 1'b0;
    else if (strb.loadTx)   sdoEn <= 1'b1;
    else if (strb.frameEnd) sdoEn <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      chanOut <= '0;
    else if (strb.commit && rxShift[FRAME_BITS-1 -: OP_W] == SET_OPCODE)
      chanOut <= rxShift[CHANNELS-1:0];
  end

  assign sdo = sdoEn & txShift[FRAME_BITS-1];

endmodule

// File: rtl/spi_out_driver.sv
module spi_out_driver
  import spi_out_driver_pkg::*;
#(
  parameter int CHANNELS    = 16,
  parameter int FRAME_BITS  = 24,
  parameter int SYNC_STAGES = 2,
  parameter logic [FRAME_BITS-CHANNELS-1:0] SET_OPCODE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                sdi,
  input  logic [CHANNELS-1:0] faultIn,
  input  logic                ovIn,
  output logic [CHANNELS-1:0] chanOut,
  output logic                sdo,
  output logic                sdoEn
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  strobe_t          strb;
  logic             sdiBit;
  logic [CNT_W-1:0] bitCount;

  spi_out_driver_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .sclk    (sclk),
    .sdi     (sdi),
    .strb    (strb),
    .sdiBit  (sdiBit),
    .bitCount(bitCount)
  );

  spi_out_driver_datapath #(
    .CHANNELS  (CHANNELS),
    .FRAME_BITS(FRAME_BITS),
    .SET_OPCODE(SET_OPCODE)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .sdiBit (sdiBit),
    .faultIn(faultIn),
    .ovIn   (ovIn),
    .chanOut(chanOut),
    .sdo    (sdo),
    .sdoEn  (sdoEn)
  );

endmodule

// File: rtl/spi_out_driver_chk.sv
module spi_out_driver_chk #(
  parameter int CHANNELS   = 16,
  parameter int FRAME_BITS = 24,
  parameter int CNT_W      = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic [CHANNELS-1:0] chanOut,
  input logic                sdo,
  input logic                sdoEn,
  input logic                commit,
  input logic                loadTx,
  input logic [CNT_W-1:0]    bitCount
);

  // R1: reset holds all channels off and the output driver disabled
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |-> (chanOut == '0 && !sdoEn));

  // R2: the driver enable only opens after a status capture
  a_r2_open_after_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEn) |-> $past(loadTx));

  // R2: driver stays off while chip select has been high for a while
  a_r2_closed_idle: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !sdoEn);

  // R2: data out is quiet while the driver is off
  a_r2_sdo_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEn |-> !sdo);

  // R6: channel latch only moves right after a frame commit
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(commit) |-> $stable(chanOut));

  // R7: any latch change follows a frame of exactly the full length
  a_r7_full_frame: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanOut) |-> $past(bitCount) == CNT_W'(FRAME_BITS));

endmodule

bind spi_out_driver spi_out_driver_chk #(
  .CHANNELS  (CHANNELS),
  .FRAME_BITS(FRAME_BITS),
  .CNT_W     (CNT_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .chanOut (chanOut),
  .sdo     (sdo),
  .sdoEn   (sdoEn),
  .commit  (strb.commit),
  .loadTx  (strb.loadTx),
  .bitCount(bitCount)
);

// File: tb/sim_spi_out_driver.sv
`timescale 1ns/1ps
module sim_spi_out_driver;

  localparam int H = 8;  // serial half period in block clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0, ovIn = 1'b0;
  logic [15:0] faultIn = '0;
  logic [15:0] chanOut;
  logic sdo, sdoEn;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;
  logic [15:0] curOut = '0;

  bit    expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  spi_out_driver u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .faultIn(faultIn), .ovIn(ovIn), .chanOut(chanOut), .sdo(sdo), .sdoEn(sdoEn)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [23:0] act, input logic [23:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the expected status bit at each host sampling edge
  always @(posedge sclk) begin
    if (!csN && expQ.size() > 0) begin
      automatic bit e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      chk(sdo === e && sdoEn === 1'b1, t, {22'b0, sdoEn, sdo}, {22'b0, 1'b1, e});
    end
  end

  // Driver: one host frame, expected status bits pushed to the scoreboard
  task automatic frame(input logic [23:0] cmd, input int nbits,
                       input logic [15:0] flt, input logic ov,
                       input bit highStart, input bit midChange,
                       input logic [15:0] expOut, input string tag);
    logic [23:0] st;
    faultIn = flt;
    ovIn    = ov;
    st = {(|flt) | ov, ov, 6'b0, flt};
    for (int i = 0; i < nbits; i++) begin
      expQ.push_back(i < 24 ? st[23-i] : 1'b0);
      tagQ.push_back(i == 0 ? {"R3 ", tag} : (i < 24 ? {"R4 ", tag} : {"R4 tail ", tag}));
    end
    waitClk(H);
    if (highStart) begin
      sclk = 1'b1; waitClk(H);
      csN  = 1'b0; waitClk(H);
      sclk = 1'b0; waitClk(H);
    end else begin
      csN = 1'b0; waitClk(H);
    end
    chk(sdoEn === 1'b1, {"R2 open ", tag}, {23'b0, sdoEn}, 24'd1);
    for (int i = 0; i < nbits; i++) begin
      sdi  = (i < 24) ? cmd[23-i] : 1'b0;
      sclk = 1'b1; waitClk(H);
      sclk = 1'b0; waitClk(H);
      if (midChange && i == 3) begin
        faultIn = ~flt;
        ovIn    = ~ov;
      end
    end
    chk(chanOut === curOut, {"R6 ", tag}, {8'b0, chanOut}, {8'b0, curOut});
    csN = 1'b1;
    waitClk(H);
    chk(chanOut === expOut, tag, {8'b0, chanOut}, {8'b0, expOut});
    chk(sdoEn === 1'b0 && sdo === 1'b0, {"R2 close ", tag},
        {22'b0, sdoEn, sdo}, 24'd0);
    chk(expQ.size() == 0, {"R4 count ", tag}, 24'(expQ.size()), 24'd0);
    expQ.delete();
    tagQ.delete();
    curOut = expOut;
    faultIn = '0;
    ovIn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    faultIn = 16'hFFFF;
    waitClk(5);
    chk(chanOut === 16'h0 && sdoEn === 1'b0, "R1 reset", {7'b0, sdoEn, chanOut}, 24'd0);
    @(negedge clk) rstN = 1'b1;
    faultIn = '0;
    waitClk(5);

    frame(24'h00A5C3, 24, 16'h0000, 1'b0, 0, 0, 16'hA5C3, "R5 basic");
    frame(24'h0000FF, 24, 16'h8001, 1'b0, 0, 0, 16'h00FF, "R5 R3 faults");
    frame(24'h00FFFF, 24, 16'h0000, 1'b1, 0, 0, 16'hFFFF, "R5 R3 overvoltage");
    frame(24'h001234, 23, 16'h0400, 1'b0, 0, 0, 16'hFFFF, "R7 short");
    frame(24'h001234, 25, 16'h0000, 1'b1, 0, 0, 16'hFFFF, "R7 long");
    frame(24'h5A1234, 24, 16'h0000, 1'b0, 0, 0, 16'hFFFF, "R8 opcode");

    // R9: serial activity with chip select high
    for (int i = 0; i < 30; i++) begin
      sdi = i[0];
      sclk = 1'b1; waitClk(3);
      sclk = 1'b0; waitClk(3);
    end
    waitClk(H);
    chk(chanOut === 16'hFFFF, "R9 latch", {8'b0, chanOut}, 24'h00FFFF);
    chk(sdoEn === 1'b0 && sdo === 1'b0, "R9 driver", {22'b0, sdoEn, sdo}, 24'd0);
    frame(24'h00C00C, 24, 16'h0010, 1'b0, 0, 0, 16'hC00C, "R9 next frame");

    frame(24'h000F0F, 24, 16'h0000, 1'b0, 1, 0, 16'h0F0F, "R10 high clock");
    frame(24'h000000, 24, 16'h1234, 1'b0, 0, 1, 16'h0000, "R11 snapshot");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule